// File: doc/BRIEF.md
# Envelope Generator with Piecewise-Exponential Decay

This block produces the 8-bit amplitude contour of one synthesizer voice. A gate bit starts an attack that ramps the level up to full scale. The level then falls toward a programmable sustain floor, and it drops again once the gate is released. Each ramp speed comes from a 4-bit code. The block divides the clock down to that speed with a free-running prescaler, and a second divider stretches the falling ramps so that they approximate an exponential curve.

Software programs the block through a single write strobe with a 2-bit register select. The select value 0 carries the gate, 1 carries the attack and decay codes, and 2 carries the sustain and release codes. The current level appears on `level` on every cycle, and this output also serves as the software read-back value.

Top module: `adsr_env`

## Requirements
- R1: A synchronous active-high reset sets the level to 0x00, clears the prescaler, the divider, the gate and all four codes, sets the divider period to 1, selects the release state with the rate for code 0, and sets the zero-freeze flag, so the level holds at 0x00 after reset.
- R2: Each code selects a prescaler match value by its index, with codes 0 to 15 giving 9, 32, 63, 95, 149, 220, 267, 313, 392, 977, 1954, 3126, 3907, 11720, 19532 and 31251. The prescaler increments on every cycle and clears when it equals the match value, so with code 0 an attack step occurs every 9 cycles.
- R3: The prescaler is 15 bits wide, and no write clears it. If the match value drops below the current count, the count climbs to 0x7FFF, continues at 0x0001 (the value 0 is skipped), and only then can it match, which delays the next step by roughly 32768 cycles.
- R4: When the gate rises, the block enters attack, loads the attack rate and clears the zero-freeze flag. In attack, every match adds 1 to the level modulo 256. When the level reaches 0xFF, the block moves to decay-sustain and loads the decay rate, so with code 0 the level climbs from 0x01 to 0xFF in 254*9 cycles.
- R5: In decay-sustain, a step lowers the level by 1 unless the level equals the sustain code copied into both nibbles (for example, code 0xA holds the level at 0xAA).
- R6: When the gate falls, the block enters release and loads the release rate. A release step subtracts 1 modulo 256, so an unfrozen level of 0x00 in release wraps to 0xFF and keeps falling.
- R7: Outside attack, a match advances a divider, and the level steps only when the advanced divider equals its period, after which the divider clears. After every step, the new level sets the period: 0xFF sets 1, 0x5D sets 2, 0x36 sets 4, 0x1A sets 8, 0x0E sets 16, 0x06 sets 30 and 0x00 sets 1. With all codes 0, the level takes (254+756)*9 cycles to go from 0x01 up and back down to 0x00.
- R8: Any step that lands on 0x00, including an attack step that wraps from 0xFF, sets the zero-freeze flag. While the flag is set, the level does not change, and only a rising gate clears the flag.
- R9: A write with select 0 takes the gate from data bit 0. A write with select 1 stores the attack code from bits 7:4 and the decay code from bits 3:0, and reloads the match value if the state is attack or decay-sustain. A write with select 2 stores the sustain code from bits 7:4 and the release code from bits 3:0, and reloads the match value if the state is release. A write with select 3 does nothing.
- R10: The block applies a write first, and the step made on that same clock edge then uses the updated state and match value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 gate, 1 attack/decay, 2 sustain/release |
| wr_data | input | 8 | Write data |
| level | output | 8 | Envelope level, also the read-back value |

## Verification
The bench builds the block with the default 15-bit prescaler, so the real 0x7FFF-to-0x0001 wrap and the full 31251-cycle slowest rate both run at their true length. Code 0 keeps one complete attack-and-decay cycle near 9000 cycles, so a cycle-exact model can run alongside the design over the whole contour, including every breakpoint of the divider. A deliberate drop of the release rate while the prescaler holds about 200 counts brings the roughly 32000-cycle wrap delay into the run.

// File: rtl/adsr_env.sv
module adsr_env #(
  parameter int PRESC_W = 15
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] level
);
  localparam logic [1:0] ST_ATK = 2'd0;
  localparam logic [1:0] ST_DEC = 2'd1;
  localparam logic [1:0] ST_REL = 2'd2;
  localparam int XW = 5;

  function automatic logic [PRESC_W-1:0] rate_of(input logic [3:0] code);
    case (code)
      4'd0:    rate_of = PRESC_W'(9);
      4'd1:    rate_of = PRESC_W'(32);
      4'd2:    rate_of = PRESC_W'(63);
      4'd3:    rate_of = PRESC_W'(95);
      4'd4:    rate_of = PRESC_W'(149);
      4'd5:    rate_of = PRESC_W'(220);
      4'd6:    rate_of = PRESC_W'(267);
      4'd7:    rate_of = PRESC_W'(313);
      4'd8:    rate_of = PRESC_W'(392);
      4'd9:    rate_of = PRESC_W'(977);
      4'd10:   rate_of = PRESC_W'(1954);
      4'd11:   rate_of = PRESC_W'(3126);
      4'd12:   rate_of = PRESC_W'(3907);
      4'd13:   rate_of = PRESC_W'(11720);
      4'd14:   rate_of = PRESC_W'(19532);
      default: rate_of = PRESC_W'(31251);
    endcase
  endfunction

  logic [1:0]         st, st_n;
  logic [7:0]         lvl, lvl_n;
  logic [3:0]         atk, atk_n, dcy, dcy_n, sus, sus_n, rel, rel_n;
  logic               gate, gate_n, frz, frz_n;
  logic [PRESC_W-1:0] pre, pre_n, per, per_n;
  logic [PRESC_W:0]   pre_inc;
  logic [XW-1:0]      xcnt, xcnt_n, xper, xper_n, xinc;

  assign pre_inc = {1'b0, pre} + 1'b1;
  assign xinc    = xcnt + 1'b1;
  assign level   = lvl;

  always_comb begin
    st_n = st; lvl_n = lvl; atk_n = atk; dcy_n = dcy; sus_n = sus; rel_n = rel;
    gate_n = gate; frz_n = frz; per_n = per; xcnt_n = xcnt; xper_n = xper;

    if (wr_en) begin
      case (wr_sel)
        2'd0: begin
          if (!gate && wr_data[0]) begin
            st_n = ST_ATK; per_n = rate_of(atk); frz_n = 1'b0;
          end else if (gate && !wr_data[0]) begin
            st_n = ST_REL; per_n = rate_of(rel);
          end
          gate_n = wr_data[0];
        end
        2'd1: begin
          atk_n = wr_data[7:4]; dcy_n = wr_data[3:0];
          if (st == ST_ATK)      per_n = rate_of(wr_data[7:4]);
          else if (st == ST_DEC) per_n = rate_of(wr_data[3:0]);
        end
        2'd2: begin
          sus_n = wr_data[7:4]; rel_n = wr_data[3:0];
          if (st == ST_REL) per_n = rate_of(wr_data[3:0]);
        end
        default: ;
      endcase
    end

    pre_n = pre_inc[PRESC_W] ? PRESC_W'(1) : pre_inc[PRESC_W-1:0];

    if (pre_n == per_n) begin
      pre_n = '0;
      if (st_n == ST_ATK || xinc == xper) begin
        xcnt_n = '0;
        if (!frz_n) begin
          case (st_n)
            ST_ATK: begin
              lvl_n = lvl + 8'd1;
              if (lvl_n == 8'hFF) begin
                st_n = ST_DEC; per_n = rate_of(dcy_n);
              end
            end
            ST_DEC:  if (lvl != {sus_n, sus_n}) lvl_n = lvl - 8'd1;
            default: lvl_n = lvl - 8'd1;
          endcase
          case (lvl_n)
            8'hFF: xper_n = XW'(1);
            8'h5D: xper_n = XW'(2);
            8'h36: xper_n = XW'(4);
            8'h1A: xper_n = XW'(8);
            8'h0E: xper_n = XW'(16);
            8'h06: xper_n = XW'(30);
            8'h00: begin xper_n = XW'(1); frz_n = 1'b1; end
            default: ;
          endcase
        end
      end else begin
        xcnt_n = xinc;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_REL; lvl <= '0; atk <= '0; dcy <= '0; sus <= '0; rel <= '0;
      gate <= 1'b0; frz <= 1'b1; pre <= '0; per <= rate_of(4'd0);
      xcnt <= '0; xper <= XW'(1);
    end else begin
      st <= st_n; lvl <= lvl_n; atk <= atk_n; dcy <= dcy_n; sus <= sus_n; rel <= rel_n;
      gate <= gate_n; frz <= frz_n; pre <= pre_n; per <= per_n;
      xcnt <= xcnt_n; xper <= xper_n;
    end
  end
endmodule

module adsr_env_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [1:0] wr_sel,
  input logic [7:0] wr_data,
  input logic [7:0] level,
  input logic [1:0] st,
  input logic       frz,
  input logic       gate,
  input logic [3:0] sus
);
  logic rst_q = 1'b0;
  always_ff @(posedge clk) rst_q <= rst;

  always @(negedge clk)
    if (rst_q) a_r1_reset_zero: assert (level == 8'h00);

  a_r4_attack_up: assert property (@(posedge clk) disable iff (rst)
    (st == 2'd0 && !wr_en) |=> (level == $past(level) || level == $past(level) + 8'd1));

  a_r6_release_down: assert property (@(posedge clk) disable iff (rst)
    (st == 2'd2 && !wr_en) |=> (level == $past(level) || level == $past(level) - 8'd1));

  a_r5_sustain_floor: assert property (@(posedge clk) disable iff (rst)
    (st == 2'd1 && !wr_en && level == {sus, sus}) |=> level == $past(level));

  a_r8_frozen_hold: assert property (@(posedge clk) disable iff (rst)
    (frz && !(wr_en && wr_sel == 2'd0)) |=> (frz && level == $past(level)));

  a_r4_gate_rise: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd0 && wr_data[0] && !gate) |=> (st != 2'd2 && !frz));

  a_r6_gate_fall: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd0 && !wr_data[0] && gate) |=> st == 2'd2);
endmodule

bind adsr_env adsr_env_chk chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .level(level), .st(st), .frz(frz), .gate(gate), .sus(sus)
);

// File: tb/adsr_env_tb_top.sv
module adsr_env_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] level;

  always #2 clk = ~clk;

  adsr_env dut_i (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
                  .wr_data(wr_data), .level(level));

  int checks = 0, errors = 0, cyc = 0;
  string cur_req = "R1";
  bit [7:0] exp_q[$];
  bit done = 0;

  int rates[16] = '{9, 32, 63, 95, 149, 220, 267, 313, 392, 977, 1954, 3126,
                    3907, 11720, 19532, 31251};
  int m_lvl, m_rc, m_rp, m_x, m_xp, m_st, m_a, m_d, m_s, m_r, m_g;
  bit m_fz, m_step;

  function void model_write(input logic [1:0] sel, input logic [7:0] d);
    if (sel == 2'd0) begin
      if (m_g == 0 && d[0]) begin m_st = 0; m_rp = rates[m_a]; m_fz = 0; end
      else if (m_g == 1 && !d[0]) begin m_st = 2; m_rp = rates[m_r]; end
      m_g = d[0];
    end else if (sel == 2'd1) begin
      m_a = d[7:4]; m_d = d[3:0];
      if (m_st == 0) m_rp = rates[m_a];
      else if (m_st == 1) m_rp = rates[m_d];
    end else if (sel == 2'd2) begin
      m_s = d[7:4]; m_r = d[3:0];
      if (m_st == 2) m_rp = rates[m_r];
    end
  endfunction

  // Reference model and scoreboard driver
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_lvl = 0; m_a = 0; m_d = 0; m_s = 0; m_r = 0; m_g = 0; m_rc = 0; m_x = 0;
      m_xp = 1; m_st = 2; m_rp = rates[0]; m_fz = 1;
    end else begin
      if (wr_en) model_write(wr_sel, wr_data);
      m_rc++;
      if (m_rc >= 32768) m_rc = (m_rc + 1) % 32768;
      if (m_rc == m_rp) begin
        m_rc = 0;
        if (m_st == 0) m_step = 1;
        else begin m_x++; m_step = (m_x == m_xp); end
        if (m_step) begin
          m_x = 0;
          if (!m_fz) begin
            if (m_st == 0) begin
              m_lvl = (m_lvl + 1) % 256;
              if (m_lvl == 255) begin m_st = 1; m_rp = rates[m_d]; end
            end else if (m_st == 1) begin
              if (m_lvl != m_s * 17) m_lvl--;
            end else m_lvl = (m_lvl + 255) % 256;
            case (m_lvl)
              255: m_xp = 1;
              93:  m_xp = 2;
              54:  m_xp = 4;
              26:  m_xp = 8;
              14:  m_xp = 16;
              6:   m_xp = 30;
              0:   begin m_xp = 1; m_fz = 1; end
              default: ;
            endcase
          end
        end
      end
    end
    exp_q.push_back(m_lvl[7:0]);
  end

  // Monitor
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      bit [7:0] e;
      e = exp_q.pop_front();
      checks++;
      if (level !== e) begin
        errors++;
        $display("FAIL %s scoreboard: level=%h expected=%h", cur_req, level, e);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_level(input logic [7:0] v, input int maxc);
    for (int k = 0; k < maxc && level !== v; k++) @(negedge clk);
  endtask

  task automatic wait_change(input int maxc, output int n);
    logic [7:0] old;
    old = level; n = 0;
    while (level === old && n < maxc) begin @(negedge clk); n++; end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int n, t1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(level == 8'h00, "R1", "level after reset", level, 0);
    repeat (50) @(negedge clk);
    chk(level == 8'h00, "R1", "frozen after reset", level, 0);

    // Full envelope with all codes 0
    cur_req = "R4";
    wr(2'd2, 8'h00); wr(2'd1, 8'h00); wr(2'd0, 8'h01);
    wait_level(8'h01, 100);
    t1 = cyc;
    wait_change(100, n);
    chk(n == 9, "R2", "attack step spacing code 0", n, 9);
    wait_level(8'hFF, 5000);
    chk(level == 8'hFF && cyc - t1 == 254 * 9, "R4", "cycles 0x01 to 0xFF", cyc - t1, 254 * 9);
    cur_req = "R7";
    wait_level(8'hF0, 2000);
    wait_change(100, n);
    chk(n == 9, "R7", "spacing with period 1", n, 9);
    wait_level(8'h50, 3000);
    wait_change(100, n);
    chk(n == 18, "R7", "spacing with period 2", n, 18);
    wait_level(8'h05, 8000);
    wait_change(400, n);
    chk(n == 270, "R7", "spacing with period 30", n, 270);
    wait_level(8'h00, 3000);
    chk(level == 8'h00 && cyc - t1 == (254 + 756) * 9, "R7", "full envelope cycles",
        cyc - t1, (254 + 756) * 9);
    cur_req = "R8";
    repeat (300) @(negedge clk);
    chk(level == 8'h00, "R8", "frozen at zero with gate high", level, 0);
    wr(2'd0, 8'h00);
    repeat (50) @(negedge clk);
    chk(level == 8'h00, "R8", "gate fall keeps freeze", level, 0);

    // Code nibbles, reload and same-edge ordering
    cur_req = "R9";
    wr(2'd2, 8'hA0); wr(2'd1, 8'h10); wr(2'd0, 8'h01);
    wait_level(8'h01, 200);
    wait_change(200, n);
    chk(n == 32, "R9", "attack code 1 spacing", n, 32);
    cur_req = "R10";
    wr(2'd1, 8'h00);
    wait_change(100, n);
    chk(n + 1 == 9, "R10", "reloaded attack rate spacing", n + 1, 9);
    cur_req = "R5";
    wait_level(8'hFF, 5000);
    wait_level(8'hAA, 2000);
    repeat (500) @(negedge clk);
    chk(level == 8'hAA, "R5", "sustain floor 0xAA", level, 8'hAA);

    // Release wrap from unfrozen zero
    cur_req = "R6";
    wr(2'd1, 8'hF0);
    wr(2'd0, 8'h00);
    wait_level(8'h00, 20000);
    chk(level == 8'h00, "R6", "release reaches zero", level, 0);
    wr(2'd0, 8'h01); wr(2'd0, 8'h00);
    wait_change(100, n);
    chk(level == 8'hFF, "R6", "release wraps 0x00 to 0xFF", level, 8'hFF);

    // Attack wrap 0xFF to 0x00 freezes
    cur_req = "R8";
    wr(2'd1, 8'h00); wr(2'd0, 8'h01);
    wait_change(100, n);
    chk(level == 8'h00, "R8", "attack wraps to zero", level, 0);
    repeat (200) @(negedge clk);
    chk(level == 8'h00, "R8", "frozen after attack wrap", level, 0);

    // Prescaler wrap delay
    cur_req = "R3";
    wr(2'd2, 8'hFF); wr(2'd1, 8'h0F); wr(2'd0, 8'h00); wr(2'd0, 8'h01);
    wait_level(8'hFF, 5000);
    wr(2'd0, 8'h00);
    repeat (200) @(negedge clk);
    wr(2'd2, 8'hF0);
    wait_change(40000, n);
    chk(level == 8'hFE && n > 30000 && n < 33000, "R3", "wrap delay cycles", n, 32560);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule